// File: doc/BRIEF.md
# Register Write Guard

This block sits in front of a peripheral's control registers and decides, for every register access, whether a write may go through. Each access carries a 6-bit requester tag. The guard holds a 64-bit permission mask, one bit per tag, split across two 32-bit enable words that live inside the guard itself. A write to any ordinary register needs two things: the writer's mask bit set and the normal-level unlock input active. The two enable words do not consult the mask at all. They can be written only while the stricter safe-level unlock input is active.

An accepted write to an ordinary register is passed on through a one-cycle forward strobe together with its address and data. A rejected write produces an error response and changes nothing. Reads are never filtered. A read of an enable word returns its contents, and a read of any other address is answered without error and with zero data, because the register owner supplies that data. Every request receives exactly one response, in the cycle after it is presented.

Top module: `regwr_guard`

## Requirements
- R1: After reset both enable words read as all ones, and no response or forward strobe is active until a request arrives.
- R2: A request held for one cycle produces `rspValid` for exactly one cycle, in the cycle after the request. No response appears while the guard is idle.
- R3: A write to an ordinary register with its tag bit set and `unlockNorm` high is accepted: `rspErr`=0 and `fwdWrEn`=1, with `fwdAddr`/`fwdWdata` equal to the request. Tags 0..31 use bit `tag` of the word at byte address 0xE0. Tags 32..63 use bit `tag-32` of the word at 0xE4.
- R4: A write to an ordinary register whose tag bit is clear gives `rspErr`=1 and no forward strobe.
- R5: A write to an ordinary register while `unlockNorm` is low gives `rspErr`=1 and no forward strobe. `unlockSafe` does not stand in for it.
- R6: A write to an enable word while `unlockSafe` is high is accepted whatever the writer's tag bit and `unlockNorm`. The new value reads back, and no forward strobe is raised.
- R7: A write to an enable word while `unlockSafe` is low gives `rspErr`=1 and leaves the word unchanged, even when `unlockNorm` is high.
- R8: When the tag check and the normal unlock check both fail on one write, exactly one error response is produced.
- R9: Reads are never rejected. A read of an enable word returns its value, and a read of any other address returns zero with no forward strobe, whatever the tag and unlock inputs.
- R10: Enable words decode only at the exact word-aligned addresses 0xE0 and 0xE4. Any other address, such as 0xE1, is treated as an ordinary register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 8 | Register byte address |
| reqTag | input | 6 | Requester tag |
| reqWdata | input | 32 | Write data |
| unlockNorm | input | 1 | Normal-level unlock status |
| unlockSafe | input | 1 | Safe-level unlock status |
| rspValid | output | 1 | Response for the previous cycle's request |
| rspErr | output | 1 | Error acknowledge |
| rspRdata | output | 32 | Enable-word read data, zero otherwise |
| fwdWrEn | output | 1 | Accepted ordinary-register write strobe |
| fwdAddr | output | 8 | Address of the forwarded write |
| fwdWdata | output | 32 | Data of the forwarded write |

## Verification
A wrong bit in the enable words shows up at the ports only through its effects. Either a later write from the affected tag is rejected or passed when it should not be, or a readback of the word returns the wrong value. For that reason every mask change is followed by a readback and by writes from tags on both sides of the changed bit, including tags in the upper word. A bad decision in the control shows up one cycle after the request, as a wrong `rspErr` or `fwdWrEn`. A stuck or duplicated response shows up in the idle cycle that follows.

// File: rtl/regwr_guard_pkg.sv
`timescale 1ns/1ps
package regwr_guard_pkg;
  // strobes from the decision logic to the datapath
  typedef struct packed {
    logic enWr;    // write selected enable word
    logic fwdWr;   // pass write to ordinary register
    logic rdEn;    // return enable word on read
    logic ackOk;   // good response
    logic ackErr;  // error response
  } strobe_t;
endpackage

// File: rtl/regwr_guard_ctrl.sv
`timescale 1ns/1ps
module regwr_guard_ctrl
  import regwr_guard_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int NUM_WORDS = 2,
  parameter int ENA_BASE  = 'hE0,
  parameter int IDX_W     = 1
) (
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              unlockNorm,
  input  logic              unlockSafe,
  input  logic              tagOk,
  output strobe_t           stb,
  output logic [IDX_W-1:0]  enIdx
);
  logic [NUM_WORDS-1:0] hitVec;
  logic enHit;
  logic wrOk;

  // exact, word-aligned decode of each enable word (R10)
  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_dec
    assign hitVec[g] = (reqAddr == ADDR_W'(ENA_BASE + 4 * g));
  end

  always_comb begin
    enIdx = '0;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (hitVec[i]) enIdx = IDX_W'(i);
    end
  end

  assign enHit = |hitVec;

  // enable words: safe unlock only, mask ignored (R6, R7)
  // others: mask bit and normal unlock together (R3, R4, R5)
  assign wrOk = enHit ? unlockSafe : (tagOk && unlockNorm);

  always_comb begin
    stb.enWr   = reqValid && reqWrite && enHit && unlockSafe;
    stb.fwdWr  = reqValid && reqWrite && !enHit && tagOk && unlockNorm;
    stb.rdEn   = reqValid && !reqWrite && enHit;
    stb.ackOk  = reqValid && (!reqWrite || wrOk);      // reads never blocked (R9)
    stb.ackErr = reqValid && reqWrite && !wrOk;        // single error (R8)
  end

  always_comb begin
    a_r8_one_outcome: assert (!(stb.ackOk && stb.ackErr));
  end
endmodule

// File: rtl/regwr_guard_dpath.sv
`timescale 1ns/1ps
module regwr_guard_dpath
  import regwr_guard_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int TAG_W     = 6,
  parameter int NUM_WORDS = 2,
  parameter int IDX_W     = 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     stb,
  input  logic [IDX_W-1:0]            enIdx,
  input  logic [ADDR_W-1:0]           reqAddr,
  input  logic [TAG_W-1:0]            reqTag,
  input  logic [DATA_W-1:0]           reqWdata,
  output logic                        tagOk,
  output logic [NUM_WORDS*DATA_W-1:0] maskVec,
  output logic                        rspValid,
  output logic                        rspErr,
  output logic [DATA_W-1:0]           rspRdata,
  output logic                        fwdWrEn,
  output logic [ADDR_W-1:0]           fwdAddr,
  output logic [DATA_W-1:0]           fwdWdata
);
  logic [DATA_W-1:0] enWord [NUM_WORDS];

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                  enWord[g] <= '1;  // R1
      else if (stb.enWr && enIdx == IDX_W'(g))    enWord[g] <= reqWdata;
    end
    assign maskVec[g*DATA_W +: DATA_W] = enWord[g];

    a_r7_word_hold: assert property (@(posedge clk) disable iff (!rstN)
      !$past(stb.enWr && enIdx == IDX_W'(g)) |-> $stable(enWord[g]));
  end

  // low tags land in the first word, high tags in the next (R3)
  assign tagOk = maskVec[reqTag];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rspRdata <= '0;
      fwdWrEn  <= 1'b0;
      fwdAddr  <= '0;
      fwdWdata <= '0;
    end else begin
      rspValid <= stb.ackOk || stb.ackErr;
      rspErr   <= stb.ackErr;
      rspRdata <= stb.rdEn ? enWord[enIdx] : '0;
      fwdWrEn  <= stb.fwdWr;
      if (stb.fwdWr) begin
        fwdAddr  <= reqAddr;
        fwdWdata <= reqWdata;
      end
    end
  end

  a_r4_err_blocks_fwd: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> (rspValid && !fwdWrEn));
endmodule

// File: rtl/regwr_guard.sv
`timescale 1ns/1ps
module regwr_guard
  import regwr_guard_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int TAG_W    = 6,
  parameter int ENA_BASE = 'hE0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [TAG_W-1:0]  reqTag,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              unlockNorm,
  input  logic              unlockSafe,
  output logic              rspValid,
  output logic              rspErr,
  output logic [DATA_W-1:0] rspRdata,
  output logic              fwdWrEn,
  output logic [ADDR_W-1:0] fwdAddr,
  output logic [DATA_W-1:0] fwdWdata
);
  localparam int NUM_TAGS  = 1 << TAG_W;
  localparam int NUM_WORDS = NUM_TAGS / DATA_W;
  localparam int IDX_W     = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;

  strobe_t                     stb;
  logic [IDX_W-1:0]            enIdx;
  logic                        tagOk;
  logic [NUM_WORDS*DATA_W-1:0] maskVec;

  regwr_guard_ctrl #(
    .ADDR_W(ADDR_W), .NUM_WORDS(NUM_WORDS), .ENA_BASE(ENA_BASE), .IDX_W(IDX_W)
  ) u_ctrl (
    .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .unlockNorm(unlockNorm), .unlockSafe(unlockSafe), .tagOk(tagOk),
    .stb(stb), .enIdx(enIdx)
  );

  regwr_guard_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_W(TAG_W),
    .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .enIdx(enIdx), .reqAddr(reqAddr),
    .reqTag(reqTag), .reqWdata(reqWdata), .tagOk(tagOk), .maskVec(maskVec),
    .rspValid(rspValid), .rspErr(rspErr), .rspRdata(rspRdata),
    .fwdWrEn(fwdWrEn), .fwdAddr(fwdAddr), .fwdWdata(fwdWdata)
  );

  a_r2_rsp_after_req: assert property (@(posedge clk) disable iff (!rstN)
    $past(reqValid) |-> rspValid);
  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rstN)
    !$past(reqValid) |-> !rspValid);
  a_r6_mask_needs_safe: assert property (@(posedge clk) disable iff (!rstN)
    (maskVec != $past(maskVec)) |-> $past(unlockSafe));
  a_r3_fwd_needs_rights: assert property (@(posedge clk) disable iff (!rstN)
    fwdWrEn |-> $past(unlockNorm && tagOk && reqWrite));
  a_r9_read_never_err: assert property (@(posedge clk) disable iff (!rstN)
    $past(reqValid && !reqWrite) |-> (rspValid && !rspErr && !fwdWrEn));
endmodule

// File: tb/regwr_guard_tb.sv
`timescale 1ns/1ps
module regwr_guard_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [7:0]  reqAddr = '0;
  logic [5:0]  reqTag = '0;
  logic [31:0] reqWdata = '0;
  logic        unlockNorm = 1'b0;
  logic        unlockSafe = 1'b0;
  logic        rspValid, rspErr, fwdWrEn;
  logic [31:0] rspRdata, fwdWdata;
  logic [7:0]  fwdAddr;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic        gValid, gErr, gFwd;
  logic [31:0] gRdata, gFwdData;
  logic [7:0]  gFwdAddr;

  localparam logic [7:0] EN0 = 8'hE0;
  localparam logic [7:0] EN1 = 8'hE4;

  always #2 clk = ~clk;  // 250 MHz

  regwr_guard u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqTag(reqTag), .reqWdata(reqWdata),
    .unlockNorm(unlockNorm), .unlockSafe(unlockSafe),
    .rspValid(rspValid), .rspErr(rspErr), .rspRdata(rspRdata),
    .fwdWrEn(fwdWrEn), .fwdAddr(fwdAddr), .fwdWdata(fwdWdata)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  // drive one request, capture its response one cycle later
  task automatic doReq(input logic wr, input logic [7:0] addr, input logic [5:0] tag,
                       input logic [31:0] data, input logic norm, input logic safe);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqTag = tag;
    reqWdata = data; unlockNorm = norm; unlockSafe = safe;
    @(negedge clk);
    gValid = rspValid; gErr = rspErr; gRdata = rspRdata;
    gFwd = fwdWrEn; gFwdAddr = fwdAddr; gFwdData = fwdWdata;
    reqValid = 1'b0; reqWrite = 1'b0;
  endtask

  task automatic readWord(input logic [7:0] addr, output logic [31:0] val);
    doReq(1'b0, addr, 6'd0, 32'h0, 1'b0, 1'b0);
    val = gRdata;
  endtask

  task automatic tReset();
    logic [31:0] v;
    chk("R1 no response after reset", {31'b0, rspValid}, 32'h0);
    chk("R1 no forward after reset", {31'b0, fwdWrEn}, 32'h0);
    readWord(EN0, v); chk("R1 word0 reset value", v, 32'hFFFF_FFFF);
    readWord(EN1, v); chk("R1 word1 reset value", v, 32'hFFFF_FFFF);
  endtask

  task automatic tAccept();
    doReq(1'b1, 8'h10, 6'd5, 32'hA5A5_0001, 1'b1, 1'b0);
    chk("R3 ok valid", {31'b0, gValid}, 32'h1);
    chk("R3 ok no err", {31'b0, gErr}, 32'h0);
    chk("R3 fwd strobe", {31'b0, gFwd}, 32'h1);
    chk("R3 fwd addr", {24'b0, gFwdAddr}, 32'h10);
    chk("R3 fwd data", gFwdData, 32'hA5A5_0001);
    doReq(1'b1, 8'h24, 6'd40, 32'h0000_BEEF, 1'b1, 1'b0);
    chk("R3 high tag fwd", {31'b0, gFwd}, 32'h1);
    chk("R3 high tag data", gFwdData, 32'h0000_BEEF);
  endtask

  task automatic tMaskBlock();
    logic [31:0] v;
    // clear tag 5 in word0, tag 40 (bit 8) in word1
    doReq(1'b1, EN0, 6'd5, ~(32'h1 << 5), 1'b0, 1'b1);
    chk("R6 word0 write ok", {31'b0, gErr}, 32'h0);
    doReq(1'b1, EN1, 6'd40, ~(32'h1 << 8), 1'b0, 1'b1);
    chk("R6 word1 write ok", {31'b0, gErr}, 32'h0);
    chk("R6 no forward on enable write", {31'b0, gFwd}, 32'h0);
    readWord(EN1, v); chk("R6 word1 readback", v, ~(32'h1 << 8));
    doReq(1'b1, 8'h10, 6'd5, 32'h1111_1111, 1'b1, 1'b0);
    chk("R4 tag5 blocked err", {31'b0, gErr}, 32'h1);
    chk("R4 tag5 no fwd", {31'b0, gFwd}, 32'h0);
    doReq(1'b1, 8'h10, 6'd6, 32'h2222_2222, 1'b1, 1'b0);
    chk("R3 tag6 still ok", {30'b0, gErr, gFwd}, 32'h1);
    doReq(1'b1, 8'h10, 6'd40, 32'h3, 1'b1, 1'b0);
    chk("R4 tag40 blocked", {30'b0, gErr, gFwd}, 32'h2);
    doReq(1'b1, 8'h10, 6'd39, 32'h4, 1'b1, 1'b0);
    chk("R3 tag39 ok", {30'b0, gErr, gFwd}, 32'h1);
    doReq(1'b1, 8'h10, 6'd37, 32'h5, 1'b1, 1'b0);
    chk("R3 tag37 not word0 bit5", {30'b0, gErr, gFwd}, 32'h1);
  endtask

  task automatic tNormLock();
    doReq(1'b1, 8'h10, 6'd6, 32'h6, 1'b0, 1'b1);
    chk("R5 norm low err", {30'b0, gErr, gFwd}, 32'h2);
  endtask

  task automatic tEnableGate();
    logic [31:0] v;
    // tag 5 has a clear bit but the enable word ignores the mask
    doReq(1'b1, EN0, 6'd5, 32'h0F0F_FFDF, 1'b0, 1'b1);
    chk("R6 blocked tag writes enable", {30'b0, gErr, gFwd}, 32'h0);
    readWord(EN0, v); chk("R6 word0 readback", v, 32'h0F0F_FFDF);
    doReq(1'b1, EN0, 6'd6, 32'h0000_0000, 1'b1, 1'b0);
    chk("R7 no safe err", {31'b0, gErr}, 32'h1);
    readWord(EN0, v); chk("R7 word0 unchanged", v, 32'h0F0F_FFDF);
  endtask

  task automatic tDouble();
    doReq(1'b1, 8'h30, 6'd5, 32'h7, 1'b0, 1'b0);
    chk("R8 double fail valid", {31'b0, gValid}, 32'h1);
    chk("R8 double fail err", {30'b0, gErr, gFwd}, 32'h2);
    @(negedge clk);
    chk("R8 single error response", {30'b0, rspValid, rspErr}, 32'h0);
    chk("R2 idle no response", {31'b0, rspValid}, 32'h0);
  endtask

  task automatic tReads();
    logic [31:0] v;
    doReq(1'b0, 8'h10, 6'd5, 32'h0, 1'b0, 1'b0);
    chk("R9 read no err", {29'b0, gValid, gErr, gFwd}, 32'h4);
    chk("R9 other read zero", gRdata, 32'h0);
    readWord(EN1, v); chk("R9 locked read of word1", v, ~(32'h1 << 8));
  endtask

  task automatic tAlign();
    logic [31:0] v;
    doReq(1'b1, 8'hE1, 6'd6, 32'h0, 1'b0, 1'b1);
    chk("R10 misaligned treated ordinary err", {30'b0, gErr, gFwd}, 32'h2);
    doReq(1'b1, 8'hE1, 6'd6, 32'h99, 1'b1, 1'b0);
    chk("R10 misaligned forwarded", {30'b0, gErr, gFwd}, 32'h1);
    readWord(EN0, v); chk("R10 word0 untouched", v, 32'h0F0F_FFDF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tAccept();
    tMaskBlock();
    tNormLock();
    tEnableGate();
    tDouble();
    tReads();
    tAlign();
    repeat (2) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule